// File: doc/BRIEF.md
# Pushbutton Power State Controller

This block decides when a system's regulators may run, based on one logical pushbutton. The button input is active low and is already debounced. The block also takes a fault input and a software power-off bit. It moves through three states: OFF, START and ON. It raises a single regulator-enable request, and it reports its current state.

From OFF, a press starts a startup attempt. That attempt only completes if the button is held for a selectable minimum time. Writing 0 to the power-off bit starts the supply without a hold. While the block is ON, it measures how long each press lasts:
- A short press does nothing.
- A release inside a middle window runs an automatic off/on cycle with fixed phase lengths.
- Holding the button to the long limit forces the block off.

Every duration is counted in pulses of a millisecond strobe input, so time can be scaled freely. A fault aborts a startup attempt. While ON, the fault input is left to other logic.

Top module: `pb_power_ctrl`

## Requirements
- R1: After reset, `state` is 2'b00 (OFF), `reg_en` is 0 and `pwr_off_bit` is 0. The block stays in OFF until a press or a write of 0 to the power-off bit.
- R2: `state` uses these codes: 2'b00 OFF, 2'b01 START, 2'b10 ON. In OFF, a press (`press_n` low) moves the block to START on the next edge, provided the button has been released at least once since the block last entered OFF.
- R3: `reg_en` is 0 in OFF. In START it rises once DEB_MS ticks have been counted since the block entered START. In ON it is 1.
- R4: `wait_sel` selects the hold time W for a press startup: 0 selects WAIT0_MS, 1 selects WAIT1_MS, 2 selects WAIT2_MS and 3 selects WAIT3_MS (32, 500, 1000 and 2000 ms by default). If the button is still held, the block enters ON on the edge after the W-th tick since it entered START.
- R5: During START, releasing the button or raising `fault` returns the block to OFF on the next edge. If the button is still held at that point, it must be released before a new press counts.
- R6: In OFF, a write of 0 to the power-off bit moves the block to START. It then enters ON on the edge after the DEB_MS-th tick, with no press needed.
- R7: In START or ON, a write of 1 to the power-off bit makes `pwr_off_bit` read 1. The block enters OFF on the next edge, and the bit reads 0 from that edge on.
- R8: In ON, releasing a press that lasted L ticks, with L not above CYC_MIN_MS, has no effect.
- R9: In ON, releasing a press with CYC_MIN_MS < L < OFF_MS moves the block to OFF on the next edge. It stays in OFF for PHASE_MS ticks, then in START for PHASE_MS ticks, then enters ON.
- R10: In ON, once a press has lasted OFF_MS ticks, the block goes to OFF on the next edge and `reg_en` drops. Holding the button further does not start a new attempt.
- R11: In ON, `fault` has no effect on `state` or `reg_en`.
- R12: No timer advances in a cycle where `tick_ms` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_ms | input | 1 | One-cycle strobe marking each millisecond |
| press_n | input | 1 | Debounced pushbutton, low while pressed |
| fault | input | 1 | Fault report, high while a fault is present |
| pwr_off_wr | input | 1 | Write strobe for the power-off bit |
| pwr_off_wdata | input | 1 | Value written to the power-off bit |
| wait_sel | input | 2 | Selects the startup hold time |
| reg_en | output | 1 | Regulator enable request |
| state | output | 2 | Current state: 00 OFF, 01 START, 10 ON |
| pwr_off_bit | output | 1 | Current value of the power-off bit |

## Verification
Changes of state appear one edge after the input that causes them. This holds for a press, a release, a fault and a write. The bench therefore drives each input on a falling edge and reads `state` on the following falling edge. Each timed phase lasts its tick count plus one cycle, because the phase counter is cleared on the entry edge. With the tick pulsing every cycle, the bench counts the falling edges spent in each state and compares that count against the count plus one. `reg_en` is combinational from the state and the phase counter, so the number of START samples with `reg_en` high is checked as W minus DEB_MS plus one. A press length seen on release equals the number of edges at which the button was sampled low. The table in the bench picks hold lengths on both sides of each window edge.

// File: rtl/pb_pkg.sv
// Package: shared types for the pushbutton power state controller.
// Assumes: two bits are enough for the state code and the startup cause.
package pb_pkg;

    // Controller state. These codes are visible on the state port.
    typedef enum logic [1:0] {
        ST_OFF   = 2'b00,
        ST_START = 2'b01,
        ST_ON    = 2'b10
    } pb_state_t;

    // Cause of the current START phase; it picks the exit rule.
    typedef enum logic [1:0] {
        SM_PRESS = 2'b00,
        SM_REG   = 2'b01,
        SM_CYC   = 2'b10
    } pb_start_t;

endpackage

// File: rtl/pb_tick_counter.sv
// Module: pb_tick_counter
// Counts tick strobes up to LIMIT and holds there. A clear input zeroes it.
// Assumes: clear takes priority over tick, and LIMIT fits in WIDTH bits.
module pb_tick_counter #(
    parameter int WIDTH = 8,
    parameter int LIMIT = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    output logic [WIDTH-1:0] count
);

    localparam logic [WIDTH-1:0] LIM = WIDTH'(LIMIT);

    // Clear, saturating count of ticks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (clr) begin
            count <= '0;
        end else if (tick && (count < LIM)) begin
            count <= count + 1'b1;
        end
    end

    // R12: with no tick and no clear, the count must not move
    a_r12_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !tick) |=> $stable(count));

endmodule

// File: rtl/pb_wait_select.sv
// Module: pb_wait_select
// Maps the 2-bit hold selection onto one of four tick counts.
// Assumes: each count fits in WIDTH bits.
module pb_wait_select #(
    parameter int WIDTH = 11,
    parameter int WAIT0 = 32,
    parameter int WAIT1 = 500,
    parameter int WAIT2 = 1000,
    parameter int WAIT3 = 2000
) (
    input  logic [1:0]       sel,
    output logic [WIDTH-1:0] ticks
);

    // Select the startup hold time
    always_comb begin
        unique case (sel)
            2'd0:    ticks = WIDTH'(WAIT0);
            2'd1:    ticks = WIDTH'(WAIT1);
            2'd2:    ticks = WIDTH'(WAIT2);
            default: ticks = WIDTH'(WAIT3);
        endcase
    end

endmodule

// File: rtl/pb_fsm.sv
// Module: pb_fsm
// The OFF / START / ON state machine, including the press-window decisions,
// the power-off bit and the re-arm rule for the button.
// Assumes: phase_cnt counts ticks since the last state change, because the
// counter is cleared by state_chg. press_cnt counts ticks of the current
// press and is zero while the button is up.
module pb_fsm
    import pb_pkg::*;
#(
    parameter int TW      = 11,
    parameter int PW      = 14,
    parameter int DEB     = 32,
    parameter int CYC_MIN = 8000,
    parameter int OFF_T   = 12000,
    parameter int PHASE   = 500
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pressed,
    input  logic          fault,
    input  logic          wr,
    input  logic          wdata,
    input  logic [TW-1:0] wait_ticks,
    input  logic [TW-1:0] phase_cnt,
    input  logic [PW-1:0] press_cnt,
    output pb_state_t     state_o,
    output logic          state_chg,
    output logic          reg_en,
    output logic          off_bit
);

    localparam logic [TW-1:0] DEB_T   = TW'(DEB);
    localparam logic [TW-1:0] PHASE_T = TW'(PHASE);
    localparam logic [PW-1:0] MIN_P   = PW'(CYC_MIN);
    localparam logic [PW-1:0] OFF_P   = PW'(OFF_T);

    pb_state_t state_q, state_d;
    pb_start_t mode_q, mode_d;
    logic      cyc_q, cyc_d;
    logic      armed_q, armed_d;
    logic      pressed_q;
    logic      off_d;
    logic      released, cyc_len, forced;

    // Decode the press length: release edge, cycle window, long-hold limit
    always_comb begin
        released = pressed_q && !pressed;
        cyc_len  = released && (press_cnt > MIN_P) && (press_cnt < OFF_P);
        forced   = (press_cnt >= OFF_P);
    end

    // Next state, next startup cause and pending-cycle flag
    always_comb begin
        state_d = state_q;
        mode_d  = mode_q;
        cyc_d   = cyc_q;
        unique case (state_q)
            ST_OFF: begin
                if (cyc_q) begin
                    if (off_bit) begin
                        cyc_d = 1'b0;
                    end else if (phase_cnt >= PHASE_T) begin
                        state_d = ST_START;
                        mode_d  = SM_CYC;
                        cyc_d   = 1'b0;
                    end
                end else if (wr && !wdata) begin
                    state_d = ST_START;
                    mode_d  = SM_REG;
                end else if (pressed && armed_q) begin
                    state_d = ST_START;
                    mode_d  = SM_PRESS;
                end
            end
            ST_START: begin
                if (off_bit || fault) begin
                    state_d = ST_OFF;
                end else begin
                    unique case (mode_q)
                        SM_PRESS: begin
                            if (!pressed)                      state_d = ST_OFF;
                            else if (phase_cnt >= wait_ticks)  state_d = ST_ON;
                        end
                        SM_REG: begin
                            if (phase_cnt >= DEB_T)            state_d = ST_ON;
                        end
                        default: begin
                            if (phase_cnt >= PHASE_T)          state_d = ST_ON;
                        end
                    endcase
                end
            end
            default: begin
                if (off_bit || forced) begin
                    state_d = ST_OFF;
                end else if (cyc_len) begin
                    state_d = ST_OFF;
                    cyc_d   = 1'b1;
                end
            end
        endcase
    end

    // Power-off bit: a write sets it, and it clears when OFF is reached.
    // The button is re-armed only once it has been released.
    always_comb begin
        if (wr)                     off_d = wdata;
        else if (state_d == ST_OFF) off_d = 1'b0;
        else                        off_d = off_bit;

        if (!pressed)                                    armed_d = 1'b1;
        else if (state_d == ST_OFF && state_q != ST_OFF) armed_d = 1'b0;
        else                                             armed_d = armed_q;
    end

    // State and flag registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_OFF;
            mode_q    <= SM_PRESS;
            cyc_q     <= 1'b0;
            armed_q   <= 1'b0;
            pressed_q <= 1'b0;
            off_bit   <= 1'b0;
        end else begin
            state_q   <= state_d;
            mode_q    <= mode_d;
            cyc_q     <= cyc_d;
            armed_q   <= armed_d;
            pressed_q <= pressed;
            off_bit   <= off_d;
        end
    end

    // Outputs: state, change pulse for the phase timer, enable request
    always_comb begin
        state_o   = state_q;
        state_chg = (state_d != state_q);
        reg_en    = (state_q == ST_ON) ||
                    ((state_q == ST_START) && (phase_cnt >= DEB_T));
    end

    // R2: only the three defined codes appear
    a_r2_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != 2'b11);

    // R4: a press startup reaches ON only with the button held through the wait
    a_r4_hold_met: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON && $past(state_q) == ST_START && $past(mode_q) == SM_PRESS)
        |-> ($past(pressed) && $past(phase_cnt) >= $past(wait_ticks)));

    // R5: a fault during startup ends in OFF
    a_r5_fault_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_START && fault) |=> state_q == ST_OFF);

    // R7: a set power-off bit outside OFF forces OFF next
    a_r7_sw_off: assert property (@(posedge clk) disable iff (!rst_n)
        (off_bit && state_q != ST_OFF) |=> (state_q == ST_OFF && !off_bit));

    // R10: a press at the long limit while ON forces OFF
    a_r10_long_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ON && press_cnt >= OFF_P) |=> state_q == ST_OFF);

endmodule

// File: rtl/pb_power_ctrl.sv
// Module: pb_power_ctrl (top)
// Pushbutton power state controller. It measures the length of each press
// and the time spent in each phase in millisecond ticks, and drives the
// regulator enable request.
// Assumes: press_n is already debounced and synchronous to clk, and tick_ms
// is a one-cycle strobe.
module pb_power_ctrl #(
    parameter int DEB_MS     = 32,
    parameter int WAIT0_MS   = 32,
    parameter int WAIT1_MS   = 500,
    parameter int WAIT2_MS   = 1000,
    parameter int WAIT3_MS   = 2000,
    parameter int CYC_MIN_MS = 8000,
    parameter int OFF_MS     = 12000,
    parameter int PHASE_MS   = 500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_ms,
    input  logic       press_n,
    input  logic       fault,
    input  logic       pwr_off_wr,
    input  logic       pwr_off_wdata,
    input  logic [1:0] wait_sel,
    output logic       reg_en,
    output logic [1:0] state,
    output logic       pwr_off_bit
);

    import pb_pkg::*;

    localparam int M1   = (DEB_MS > PHASE_MS) ? DEB_MS : PHASE_MS;
    localparam int M2   = (WAIT0_MS > WAIT1_MS) ? WAIT0_MS : WAIT1_MS;
    localparam int M3   = (WAIT2_MS > WAIT3_MS) ? WAIT2_MS : WAIT3_MS;
    localparam int M4   = (M2 > M3) ? M2 : M3;
    localparam int TMAX = (M1 > M4) ? M1 : M4;
    localparam int TW   = $clog2(TMAX + 1);
    localparam int PW   = $clog2(OFF_MS + 1);

    logic          pressed;
    logic          state_chg;
    logic [TW-1:0] phase_cnt;
    logic [TW-1:0] wait_ticks;
    logic [PW-1:0] press_cnt;
    pb_state_t     st;

    // Active-high view of the button
    always_comb pressed = !press_n;

    // Time since the last state change
    pb_tick_counter #(.WIDTH(TW), .LIMIT(TMAX)) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_chg),
        .tick  (tick_ms),
        .count (phase_cnt)
    );

    // Length of the current press
    pb_tick_counter #(.WIDTH(PW), .LIMIT(OFF_MS)) u_press (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!pressed),
        .tick  (tick_ms),
        .count (press_cnt)
    );

    pb_wait_select #(
        .WIDTH (TW),
        .WAIT0 (WAIT0_MS),
        .WAIT1 (WAIT1_MS),
        .WAIT2 (WAIT2_MS),
        .WAIT3 (WAIT3_MS)
    ) u_wait (
        .sel   (wait_sel),
        .ticks (wait_ticks)
    );

    pb_fsm #(
        .TW      (TW),
        .PW      (PW),
        .DEB     (DEB_MS),
        .CYC_MIN (CYC_MIN_MS),
        .OFF_T   (OFF_MS),
        .PHASE   (PHASE_MS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .pressed    (pressed),
        .fault      (fault),
        .wr         (pwr_off_wr),
        .wdata      (pwr_off_wdata),
        .wait_ticks (wait_ticks),
        .phase_cnt  (phase_cnt),
        .press_cnt  (press_cnt),
        .state_o    (st),
        .state_chg  (state_chg),
        .reg_en     (reg_en),
        .off_bit    (pwr_off_bit)
    );

    // Expose the state code
    always_comb state = st;

endmodule

// File: tb/tb_pb_power_ctrl.sv
// Bench for pb_power_ctrl. Durations are scaled down through the parameters,
// and the tick pulses every cycle unless a test gates it.
module tb_pb_power_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int DEB   = 4;
    localparam int PHASE = 5;
    localparam int MINL  = 20;
    localparam int OFFL  = 30;

    localparam int S_OFF = 0, S_START = 1, S_ON = 2;

    // startup table: wait_sel, cycles in START, START cycles with reg_en high
    localparam int ST_TAB [4][3] = '{'{0, 5, 1}, '{1, 7, 3}, '{2, 9, 5}, '{3, 11, 7}};
    // ON-press table: hold edges, state after release, cycle expected
    localparam int ON_TAB [5][3] = '{'{5, S_ON, 0}, '{20, S_ON, 0}, '{21, S_OFF, 1},
                                     '{29, S_OFF, 1}, '{30, S_OFF, 0}};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b1;
    logic       press_n = 1'b1;
    logic       fault = 1'b0;
    logic       pwr_off_wr = 1'b0;
    logic       pwr_off_wdata = 1'b0;
    logic [1:0] wait_sel = 2'd0;
    logic       reg_en;
    logic [1:0] state;
    logic       pwr_off_bit;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    pb_power_ctrl #(
        .DEB_MS (DEB), .WAIT0_MS (4), .WAIT1_MS (6), .WAIT2_MS (8), .WAIT3_MS (10),
        .CYC_MIN_MS (MINL), .OFF_MS (OFFL), .PHASE_MS (PHASE)
    ) dut (
        .clk (clk), .rst_n (rst_n), .tick_ms (tick_ms), .press_n (press_n),
        .fault (fault), .pwr_off_wr (pwr_off_wr), .pwr_off_wdata (pwr_off_wdata),
        .wait_sel (wait_sel), .reg_en (reg_en), .state (state),
        .pwr_off_bit (pwr_off_bit)
    );

    task automatic chk(input string req, input int got, input int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Count falling edges spent in state st, and how many of them had reg_en high
    task automatic run_len(input int st, output int n, output int en);
        n = 0;
        en = 0;
        while (int'(state) == st && n < 500) begin
            if (reg_en) en++;
            @(negedge clk);
            n++;
        end
    endtask

    task automatic reg_on();
        int n, en;
        pwr_off_wr = 1'b1; pwr_off_wdata = 1'b0;
        @(negedge clk);
        pwr_off_wr = 1'b0;
        chk("R6 write 0 enters START", int'(state), S_START);
        run_len(S_START, n, en);
        chk("R6 START length after write", n, DEB + 1);
        chk("R6 ON after write", int'(state), S_ON);
    endtask

    task automatic reg_off();
        pwr_off_wr = 1'b1; pwr_off_wdata = 1'b1;
        @(negedge clk);
        pwr_off_wr = 1'b0;
        chk("R7 bit reads 1 before OFF", int'(pwr_off_bit), 1);
        @(negedge clk);
        chk("R7 OFF after write 1", int'(state), S_OFF);
        chk("R7 bit self-cleared", int'(pwr_off_bit), 0);
        chk("R3 reg_en low in OFF", int'(reg_en), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        fails++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int n, en;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset state", int'(state), S_OFF);
        chk("R1 reset reg_en", int'(reg_en), 0);
        chk("R1 reset bit", int'(pwr_off_bit), 0);
        repeat (40) @(negedge clk);
        chk("R1 idle stays OFF", int'(state), S_OFF);

        // Vector walk 1: press startup for every hold selection (R2, R3, R4)
        for (int i = 0; i < 4; i++) begin
            wait_sel = 2'(ST_TAB[i][0]);
            press_n = 1'b0;
            @(negedge clk);
            chk("R2 press enters START", int'(state), S_START);
            run_len(S_START, n, en);
            chk("R4 START length for hold", n, ST_TAB[i][1]);
            chk("R3 reg_en cycles in START", en, ST_TAB[i][2]);
            chk("R4 ON reached", int'(state), S_ON);
            chk("R3 reg_en in ON", int'(reg_en), 1);
            press_n = 1'b1;
            repeat (2) @(negedge clk);
            chk("R8 short startup press no action", int'(state), S_ON);
            reg_off();
        end

        // Vector walk 2: press lengths in ON (R8, R9, R10)
        for (int i = 0; i < 5; i++) begin
            reg_on();
            press_n = 1'b0;
            repeat (ON_TAB[i][0]) @(negedge clk);
            press_n = 1'b1;
            @(negedge clk);
            chk("R8 R9 R10 state after release", int'(state), ON_TAB[i][1]);
            if (ON_TAB[i][2] == 1) begin
                run_len(S_OFF, n, en);
                chk("R9 OFF phase length", n, PHASE + 1);
                run_len(S_START, n, en);
                chk("R9 START phase length", n, PHASE + 1);
                chk("R9 ON after cycle", int'(state), S_ON);
                reg_off();
            end else if (ON_TAB[i][1] == S_ON) begin
                reg_off();
            end else begin
                chk("R10 reg_en dropped", int'(reg_en), 0);
                repeat (3) @(negedge clk);
            end
        end

        // R5: release during START aborts
        wait_sel = 2'd3;
        press_n = 1'b0;
        repeat (6) @(negedge clk);
        press_n = 1'b1;
        @(negedge clk);
        chk("R5 release abort", int'(state), S_OFF);
        chk("R5 reg_en off after abort", int'(reg_en), 0);

        // R5: fault during START aborts, and a held button needs a release
        press_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R3 reg_en high after debounce", int'(reg_en), 1);
        fault = 1'b1;
        @(negedge clk);
        fault = 1'b0;
        chk("R5 fault abort", int'(state), S_OFF);
        repeat (10) @(negedge clk);
        chk("R5 held button not re-armed", int'(state), S_OFF);
        press_n = 1'b1;
        repeat (2) @(negedge clk);

        // R11: fault ignored in ON
        reg_on();
        fault = 1'b1;
        repeat (20) @(negedge clk);
        chk("R11 fault in ON state", int'(state), S_ON);
        chk("R11 fault in ON reg_en", int'(reg_en), 1);
        fault = 1'b0;
        reg_off();

        // R12: timers frozen without tick
        pwr_off_wr = 1'b1; pwr_off_wdata = 1'b0; tick_ms = 1'b0;
        @(negedge clk);
        pwr_off_wr = 1'b0;
        repeat (20) @(negedge clk);
        chk("R12 START held without tick", int'(state), S_START);
        chk("R12 reg_en low without tick", int'(reg_en), 0);
        tick_ms = 1'b1;
        run_len(S_START, n, en);
        chk("R12 START resumes on ticks", n, DEB + 1);
        chk("R12 ON after ticks", int'(state), S_ON);

        // R10: long hold forces OFF, and continued holding stays OFF
        press_n = 1'b0;
        repeat (45) @(negedge clk);
        chk("R10 long hold OFF", int'(state), S_OFF);
        chk("R10 reg_en low", int'(reg_en), 0);
        press_n = 1'b1;
        repeat (2) @(negedge clk);
        press_n = 1'b0;
        @(negedge clk);
        chk("R2 new press after release", int'(state), S_START);
        press_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 back to OFF", int'(state), S_OFF);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule